// File: doc/BRIEF.md
# I2C Register-Access Slave

This block is a slave on a two-wire I2C bus. It lets a bus master read and write a small bank of byte-wide registers that sits next to it. A fast system clock oversamples the SCL and SDA lines, and the bus is seen only through these synchronized copies. The block recognises start and stop conditions and answers a single fixed 7-bit device address. The first byte of a write transaction is taken as a register pointer. Every byte after it is written into the register bank through a strobe on the internal register port.

A read needs two transactions, because repeated start is not honoured. The first is a short write that sets only the pointer and ends with a stop. The second addresses the device with the read flag. The block then shifts register contents out MSB first for as long as the master acknowledges. The pointer keeps its value between transactions. It advances after every byte written or read and wraps at the top of the register space. SDA is driven as an open-drain enable: `sda_oe` high pulls the line low. The block changes `sda_oe` only while SCL is low.

Top module: `i2c_reg_slave`

## Requirements
- R1: While and after reset, `sda_oe` is 0, `reg_we` is 0 and `reg_addr` is 0.
- R2: A first byte whose upper seven bits equal 7'h44 (bit 0 = 0 write, 1 read) is acknowledged by pulling SDA low during the ninth clock. Any other address is not acknowledged, and no byte that follows it is acknowledged or written until a stop.
- R3: In a write transaction, the byte after the address loads the pointer. Each later byte is written to the register the pointer names. Every one of these bytes is acknowledged, and each written byte gives exactly one `reg_we` strobe, in the same cycle that the acknowledge drive starts.
- R4: The pointer, visible on `reg_addr`, increases by one in the cycle after each write strobe and after each byte sent in a read. It wraps from 15 to 0 with the default 4-bit register address.
- R5: A transaction addressed with the read flag returns the register at the current pointer, MSB first, one bit per SCL high phase. The pointer set by an earlier stop-terminated write persists into later transactions.
- R6: During a read, a master acknowledge (SDA low on the ninth clock) makes the block send the next register. A master not-acknowledge makes it release SDA and stay silent until a stop.
- R7: A start condition inside an unfinished transaction is not treated as a new transaction. Until the next stop, nothing is acknowledged, no register is written and the pointer keeps its value.
- R8: `sda_oe` only changes while SCL is low.
- R9: `reg_we` never stays high for two consecutive system clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_addr | output | ADDR_W | Register pointer, address for reads and writes |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_wdata | output | 8 | Data to write when `reg_we` is high |
| reg_rdata | input | 8 | Contents of the register at `reg_addr` |

## Verification
A write strobe and the start of the acknowledge drive happen in one and the same system clock cycle. The pointer step follows one cycle later. When that step happens at register 15, it also wraps the pointer to 0. A multi-byte write that starts at register 14 provokes all three at once. The bench judges the result by reading back registers 14, 15 and 0 and by checking that `reg_addr` reads 1 after the stop, while the bound properties tie each strobe to the acknowledge and to the pointer step.

// File: rtl/i2c_reg_slave_pkg.sv
package i2c_reg_slave_pkg;
   localparam int BYTE_W = 8;
   localparam int BIT_CNT_W = 4;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_PTR,
      ST_WDATA,
      ST_ACK,
      ST_RDATA,
      ST_RACK,
      ST_IGNORE
   } slv_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic sda_lvl,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   localparam int TOP = STAGES - 1;

   logic [TOP:0] scl_pipe;
   logic [TOP:0] sda_pipe;
   logic         scl_prev;
   logic         sda_prev;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_pipe[0] <= 1'b1;
               sda_pipe[0] <= 1'b1;
            end else begin
               scl_pipe[0] <= scl_in;
               sda_pipe[0] <= sda_in;
            end
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_pipe[s] <= 1'b1;
               sda_pipe[s] <= 1'b1;
            end else begin
               scl_pipe[s] <= scl_pipe[s-1];
               sda_pipe[s] <= sda_pipe[s-1];
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_prev <= 1'b1;
         sda_prev <= 1'b1;
      end else begin
         scl_prev <= scl_pipe[TOP];
         sda_prev <= sda_pipe[TOP];
      end
   end

   assign sda_lvl   = sda_pipe[TOP];
   assign scl_rise  = scl_pipe[TOP] & ~scl_prev;
   assign scl_fall  = ~scl_pipe[TOP] & scl_prev;
   assign start_det = scl_pipe[TOP] & scl_prev & sda_prev & ~sda_pipe[TOP];
   assign stop_det  = scl_pipe[TOP] & scl_prev & ~sda_prev & sda_pipe[TOP];
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
   import i2c_reg_slave_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h44,
   parameter int         ADDR_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sda_lvl,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic [BYTE_W-1:0] rd_byte,
   output logic              drive_low,
   output logic [ADDR_W-1:0] ptr,
   output logic              wr_stb,
   output logic [BYTE_W-1:0] wr_byte
);
   localparam logic [BIT_CNT_W-1:0] FULL_BYTE = BIT_CNT_W'(BYTE_W);
   localparam logic [BIT_CNT_W-1:0] LAST_BIT  = BIT_CNT_W'(BYTE_W - 1);

   slv_state_e            state;
   slv_state_e            after_ack;
   logic [BYTE_W-1:0]     shreg;
   logic [BIT_CNT_W-1:0]  bit_cnt;
   logic                  host_ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         after_ack <= ST_IDLE;
         shreg     <= '0;
         bit_cnt   <= '0;
         ptr       <= '0;
         drive_low <= 1'b0;
         wr_stb    <= 1'b0;
         wr_byte   <= '0;
         host_ack  <= 1'b0;
      end else begin
         wr_stb <= 1'b0;
         if (wr_stb) begin
            ptr <= ptr + 1'b1;
         end
         if (stop_det) begin
            state     <= ST_IDLE;
            drive_low <= 1'b0;
         end else if (start_det) begin
            bit_cnt   <= '0;
            drive_low <= 1'b0;
            state     <= (state == ST_IDLE) ? ST_ADDR : ST_IGNORE;
         end else begin
            unique case (state)
               ST_ADDR, ST_PTR, ST_WDATA: begin
                  if (scl_rise) begin
                     shreg   <= {shreg[BYTE_W-2:0], sda_lvl};
                     bit_cnt <= bit_cnt + 1'b1;
                  end else if (scl_fall && bit_cnt == FULL_BYTE) begin
                     bit_cnt <= '0;
                     if (state == ST_ADDR) begin
                        if (shreg[BYTE_W-1:1] == DEV_ADDR) begin
                           drive_low <= 1'b1;
                           state     <= ST_ACK;
                           after_ack <= shreg[0] ? ST_RDATA : ST_PTR;
                        end else begin
                           state <= ST_IGNORE;
                        end
                     end else if (state == ST_PTR) begin
                        ptr       <= shreg[ADDR_W-1:0];
                        drive_low <= 1'b1;
                        state     <= ST_ACK;
                        after_ack <= ST_WDATA;
                     end else begin
                        wr_stb    <= 1'b1;
                        wr_byte   <= shreg;
                        drive_low <= 1'b1;
                        state     <= ST_ACK;
                        after_ack <= ST_WDATA;
                     end
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     bit_cnt <= '0;
                     state   <= after_ack;
                     if (after_ack == ST_RDATA) begin
                        shreg     <= rd_byte;
                        drive_low <= ~rd_byte[BYTE_W-1];
                     end else begin
                        drive_low <= 1'b0;
                     end
                  end
               end
               ST_RDATA: begin
                  if (scl_fall) begin
                     if (bit_cnt == LAST_BIT) begin
                        drive_low <= 1'b0;
                        bit_cnt   <= '0;
                        ptr       <= ptr + 1'b1;
                        state     <= ST_RACK;
                     end else begin
                        shreg     <= {shreg[BYTE_W-2:0], 1'b0};
                        drive_low <= ~shreg[BYTE_W-2];
                        bit_cnt   <= bit_cnt + 1'b1;
                     end
                  end
               end
               ST_RACK: begin
                  if (scl_rise) begin
                     host_ack <= ~sda_lvl;
                  end else if (scl_fall) begin
                     if (host_ack) begin
                        shreg     <= rd_byte;
                        drive_low <= ~rd_byte[BYTE_W-1];
                        state     <= ST_RDATA;
                     end else begin
                        state <= ST_IGNORE;
                     end
                  end
               end
               default: begin
               end
            endcase
         end
      end
   end
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
   import i2c_reg_slave_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR    = 7'h44,
   parameter int         ADDR_W      = 4,
   parameter int         SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   output logic [ADDR_W-1:0] reg_addr,
   output logic              reg_we,
   output logic [7:0]        reg_wdata,
   input  logic [7:0]        reg_rdata
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (ADDR_W < 1 || ADDR_W > BYTE_W) begin : g_bad_addr
      $error("ADDR_W must lie between 1 and 8");
   end

   logic sda_lvl;
   logic scl_rise;
   logic scl_fall;
   logic start_det;
   logic stop_det;

   i2c_line_sync #(
      .STAGES(SYNC_STAGES)
   ) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_in   (scl_i),
      .sda_in   (sda_i),
      .sda_lvl  (sda_lvl),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_det(start_det),
      .stop_det (stop_det)
   );

   i2c_byte_engine #(
      .DEV_ADDR(DEV_ADDR),
      .ADDR_W  (ADDR_W)
   ) u_engine (
      .clk      (clk),
      .rst_n    (rst_n),
      .sda_lvl  (sda_lvl),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_det(start_det),
      .stop_det (stop_det),
      .rd_byte  (reg_rdata),
      .drive_low(sda_oe),
      .ptr      (reg_addr),
      .wr_stb   (reg_we),
      .wr_byte  (reg_wdata)
   );
endmodule

// File: rtl/i2c_reg_slave_chk.sv
module i2c_reg_slave_chk #(
   parameter int ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_i,
   input logic              sda_oe,
   input logic              reg_we,
   input logic [ADDR_W-1:0] reg_addr
);
   AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe != $past(sda_oe)) |-> !scl_i); // R8

   AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> !reg_we); // R9

   AST_WE_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> sda_oe); // R3

   AST_WE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> !scl_i); // R3

   AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> (reg_addr == ADDR_W'($past(reg_addr) + 1'b1))); // R4
endmodule

bind i2c_reg_slave i2c_reg_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .scl_i   (scl_i),
   .sda_oe  (sda_oe),
   .reg_we  (reg_we),
   .reg_addr(reg_addr)
);

// File: tb/i2c_reg_slave_test.sv
module i2c_reg_slave_test;
   localparam int HALF = 20;
   localparam int NVEC = 6;
   localparam logic [11:0] VEC [NVEC] = '{
      {4'h0, 8'hA5}, {4'h1, 8'h3C}, {4'h7, 8'hFF},
      {4'h9, 8'h81}, {4'hF, 8'h5A}, {4'h2, 8'hC3}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       m_scl = 1'b1;
   logic       m_sda = 1'b1;
   logic       sda_oe;
   logic       sda_bus;
   logic [3:0] reg_addr;
   logic       reg_we;
   logic [7:0] reg_wdata;
   logic [7:0] reg_rdata;
   logic [7:0] mem [16];
   logic [7:0] exp_mem [16];
   logic [3:0] exp_ptr = 4'd0;
   int         checks = 0;
   int         fails = 0;
   int         oe_bad = 0;
   int         we_bad = 0;
   int         we_total = 0;
   logic       oe_prev = 1'b0;
   logic       we_prev = 1'b0;

   always #4 clk = ~clk;

   assign sda_bus   = m_sda & ~sda_oe;
   assign reg_rdata = mem[reg_addr];

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 16; i++) mem[i] <= 8'h00;
      end else if (reg_we) begin
         mem[reg_addr] <= reg_wdata;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (sda_oe !== oe_prev && m_scl) oe_bad++;
         if (reg_we && we_prev) we_bad++;
         if (reg_we) we_total++;
      end
      oe_prev <= sda_oe;
      we_prev <= reg_we;
   end

   i2c_reg_slave uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (m_scl),
      .sda_i    (sda_bus),
      .sda_oe   (sda_oe),
      .reg_addr (reg_addr),
      .reg_we   (reg_we),
      .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      m_sda = 1'b1;
      wait_cyc(HALF / 2);
      m_scl = 1'b1;
      wait_cyc(HALF);
      m_sda = 1'b0;
      wait_cyc(HALF);
      m_scl = 1'b0;
   endtask

   task automatic bus_stop();
      m_sda = 1'b0;
      wait_cyc(HALF / 2);
      m_scl = 1'b1;
      wait_cyc(HALF);
      m_sda = 1'b1;
      wait_cyc(HALF);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) begin
         wait_cyc(HALF / 2);
         m_sda = b[i];
         wait_cyc(HALF / 2);
         m_scl = 1'b1;
         wait_cyc(HALF);
         m_scl = 1'b0;
      end
      wait_cyc(HALF / 2);
      m_sda = 1'b1;
      wait_cyc(HALF / 2);
      m_scl = 1'b1;
      wait_cyc(HALF / 2);
      ack = ~sda_bus;
      wait_cyc(HALF / 2);
      m_scl = 1'b0;
   endtask

   task automatic recv_byte(output logic [7:0] b, input logic give_ack);
      for (int i = 7; i >= 0; i--) begin
         wait_cyc(HALF);
         m_scl = 1'b1;
         wait_cyc(HALF / 2);
         b[i] = sda_bus;
         wait_cyc(HALF / 2);
         m_scl = 1'b0;
      end
      wait_cyc(HALF / 2);
      m_sda = ~give_ack;
      wait_cyc(HALF / 2);
      m_scl = 1'b1;
      wait_cyc(HALF);
      m_scl = 1'b0;
      wait_cyc(HALF / 2);
      m_sda = 1'b1;
   endtask

   task automatic write_seq(input logic [3:0] p, input logic [7:0] d0, input logic [7:0] d1,
                            input logic [7:0] d2, input int n);
      logic a;
      logic [7:0] d;
      bus_start();
      send_byte(8'h88, a);
      chk("R2 address ack on write", a, 1'b1);
      send_byte({4'h0, p}, a);
      chk("R3 pointer byte ack", a, 1'b1);
      exp_ptr = p;
      for (int k = 0; k < n; k++) begin
         d = (k == 0) ? d0 : ((k == 1) ? d1 : d2);
         send_byte(d, a);
         chk("R3 data byte ack", a, 1'b1);
         exp_mem[exp_ptr] = d;
         exp_ptr = exp_ptr + 4'd1;
      end
      bus_stop();
   endtask

   task automatic set_ptr(input logic [3:0] p);
      logic a;
      bus_start();
      send_byte(8'h88, a);
      chk("R2 address ack before pointer", a, 1'b1);
      send_byte({4'h0, p}, a);
      chk("R5 pointer set ack", a, 1'b1);
      exp_ptr = p;
      bus_stop();
   endtask

   task automatic read_check(input int n, input string req);
      logic a;
      logic [7:0] b;
      bus_start();
      send_byte(8'h89, a);
      chk("R2 address ack on read", a, 1'b1);
      for (int k = 0; k < n; k++) begin
         recv_byte(b, k < n - 1);
         chk(req, b, exp_mem[exp_ptr]);
         exp_ptr = exp_ptr + 4'd1;
      end
      wait_cyc(HALF / 2);
      chk("R6 SDA released after master NACK", sda_oe, 1'b0);
      bus_stop();
   endtask

   initial begin
      logic a;
      for (int i = 0; i < 16; i++) exp_mem[i] = 8'h00;
      wait_cyc(5);
      chk("R1 sda_oe in reset", sda_oe, 1'b0);
      chk("R1 reg_we in reset", reg_we, 1'b0);
      rst_n = 1'b1;
      wait_cyc(3);
      chk("R1 reg_addr after reset", reg_addr, 4'd0);
      chk("R1 sda_oe after reset", sda_oe, 1'b0);

      // R3 R5: table of single-byte writes, each read back in its own transaction
      for (int v = 0; v < NVEC; v++) begin
         write_seq(VEC[v][11:8], VEC[v][7:0], 8'h00, 8'h00, 1);
         set_ptr(VEC[v][11:8]);
         read_check(1, "R5 single-byte readback");
      end

      // R4: burst write that crosses the top of the register space
      write_seq(4'hE, 8'h12, 8'h34, 8'h56, 3);
      chk("R4 pointer wrapped after burst write", reg_addr, 4'd1);
      chk("R4 register 0 written by wrap", exp_mem[0], 8'h56);

      // R6: burst read with acknowledges across the wrap
      set_ptr(4'hE);
      read_check(3, "R6 burst read data");

      // R5: the pointer persists into a new read transaction
      chk("R5 pointer kept across transactions", reg_addr, exp_ptr);
      read_check(1, "R5 read at persisted pointer");

      // R2: wrong device address is ignored until stop
      bus_start();
      send_byte(8'h8A, a);
      chk("R2 foreign address not acked", a, 1'b0);
      send_byte(8'h03, a);
      chk("R2 byte after foreign address not acked", a, 1'b0);
      send_byte(8'hEE, a);
      chk("R2 data after foreign address not acked", a, 1'b0);
      bus_stop();
      set_ptr(4'h3);
      read_check(1, "R2 register untouched by foreign address");

      // R7: repeated start inside a write is ignored until stop
      bus_start();
      send_byte(8'h88, a);
      chk("R7 address ack", a, 1'b1);
      send_byte(8'h05, a);
      chk("R7 pointer ack", a, 1'b1);
      send_byte(8'h11, a);
      chk("R7 data ack", a, 1'b1);
      exp_mem[5] = 8'h11;
      exp_ptr = 4'd6;
      bus_start();
      send_byte(8'h88, a);
      chk("R7 address after repeated start not acked", a, 1'b0);
      send_byte(8'h05, a);
      chk("R7 pointer after repeated start not acked", a, 1'b0);
      send_byte(8'h99, a);
      chk("R7 data after repeated start not acked", a, 1'b0);
      bus_stop();
      chk("R7 pointer unchanged after ignored transfer", reg_addr, 4'd6);
      set_ptr(4'h5);
      read_check(1, "R7 register kept its value");

      chk("R8 sda_oe changes with SCL high", oe_bad, 0);
      chk("R9 multi-cycle write strobes", we_bad, 0);
      chk("R3 total write strobes", we_total, NVEC + 4);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule